// File: doc/BRIEF.md
# Buffer-Level Context Request Controller

This block sequences one context of a 2D transfer buffer. It compares the fill level of the local buffer with a programmed trigger threshold. From that comparison it decides when to send a line-sized 2D write (drain) or a 2D read (prefetch) to the outbound port. It holds at most one outbound request in flight, and it counts completed lines against a programmed last line.

Software-style commands arrive as single-cycle pulses. A start or a stop is held pending and applied only when the transaction-boundary input is high and no request is outstanding. A flush forces a write out of whatever data remains in the buffer. At the end of a frame the context either switches itself off (one-shot) or keeps running for the next frame (continuous), and a done pulse marks the frame. An error pulse flags an inbound read that finds the buffer empty during read operation. Address translation and data movement are handled elsewhere.

Top module: `ctx_req_ctrl`

## Requirements
- R1: With the context enabled, no request in flight and mode_i = 0 (write), wr_req_o pulses high for one cycle, in the cycle after a clock edge at which level_i >= trigger_i. A level one below the trigger raises nothing.
- R2: With the context enabled, no request in flight and mode_i = 1 (read), rd_req_o pulses for one cycle, in the cycle after an edge at which level_i < trigger_i.
- R3: mode_i = 2 (direct buffer access) and mode_i = 3 (reserved) never raise a request. While a request is in flight, no further request is raised until req_done_i has been seen.
- R4: A start pulse is held until an edge with boundary_i high and no request in flight. At that edge enabled_o rises and the line count returns to zero.
- R5: A stop pulse is held in the same way and then clears enabled_o. If a start and a stop are both pending when the boundary comes, the start wins.
- R6: In write mode with the context enabled, a flush pulse forces one write request while level_i is non-zero, whatever the threshold. A flush that arrives with a request in flight is raised after that request completes. A flush while the mode is not write is dropped.
- R7: Each req_done_i seen with a request in flight completes one line. Completing the line equal to last_line_i returns the count to zero and pulses done_o in the next cycle. last_line_i = 0 is a one-line frame.
- R8: With oneshot_i = 1, enabled_o falls together with the done pulse. With oneshot_i = 0, the context stays enabled into the next frame, and last_line_i must then be 7.
- R9: rd_access_i seen while the context is enabled in read mode and level_i is zero pulses err_o in the next cycle. In any other case, err_o stays low.
- R10: After reset all outputs are low and the context is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 write, 1 read, 2 direct, 3 reserved |
| oneshot_i | input | 1 | 1: stop at frame end; 0: continuous |
| trigger_i | input | LVL_W | Buffer-level threshold |
| last_line_i | input | LINE_W | Index of the final line of a frame |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| flush_i | input | 1 | Flush command pulse |
| level_i | input | LVL_W | Current local buffer fill level |
| boundary_i | input | 1 | Clean transaction boundary indication |
| req_done_i | input | 1 | Outbound request completed |
| rd_access_i | input | 1 | Inbound read access to the context |
| wr_req_o | output | 1 | 2D write request pulse |
| rd_req_o | output | 1 | 2D read request pulse |
| enabled_o | output | 1 | Context enabled state |
| done_o | output | 1 | Frame-complete event pulse |
| err_o | output | 1 | Read-underflow event pulse |

## Verification
The assertions assume that req_done_i comes only for a request that was raised, and that oneshot_i and last_line_i change only while the context is disabled. They also assume that continuous operation is used only with last_line_i at 7. The bench stays within these limits. It changes frame settings only after a stop has taken effect, drives req_done_i only after it has seen a request pulse, and runs its continuous-mode frame with a last line of 7. Levels are held on the far side of the trigger whenever no request is wanted, so that no stray request can satisfy a check by accident.

// File: rtl/crc_pkg.sv
package crc_pkg;
  typedef enum logic [1:0] {
    XM_WRITE  = 2'd0,
    XM_READ   = 2'd1,
    XM_DIRECT = 2'd2,
    XM_RSVD   = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/crc_cmd_seq.sv
// Start/stop sequencing and the enabled state of the context.
module crc_cmd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic boundary_i,
  input  logic idle_i,
  input  logic frame_end_i,
  input  logic oneshot_i,
  output logic en_o,
  output logic arm_o,
  output logic hold_o
);
  logic pend_start_q, pend_start_d;
  logic pend_stop_q, pend_stop_d;
  logic en_q, en_d;
  logic start_seen, stop_seen, apply;

  always_comb begin
    start_seen  = pend_start_q | start_i;
    stop_seen   = pend_stop_q | stop_i;
    apply       = boundary_i & idle_i;
    arm_o       = apply & start_seen;
    hold_o      = apply & (start_seen | stop_seen);
    pend_start_d = start_seen & ~apply;
    pend_stop_d  = stop_seen & ~apply;
    en_d = en_q;
    if (arm_o)                       en_d = 1'b1;
    else if (hold_o)                 en_d = 1'b0;
    else if (frame_end_i && oneshot_i) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_start_q <= 1'b0;
      pend_stop_q  <= 1'b0;
      en_q         <= 1'b0;
    end else begin
      pend_start_q <= pend_start_d;
      pend_stop_q  <= pend_stop_d;
      en_q         <= en_d;
    end
  end

  assign en_o = en_q;

  a_r4_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(boundary_i) && $past(idle_i));

  a_r8_oneshot_off: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i && oneshot_i |=> !en_q);
endmodule

// File: rtl/crc_line_trk.sv
// Line counter and frame-complete event.
module crc_line_trk #(
  parameter int LINE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              step_i,
  input  logic [LINE_W-1:0] last_line_i,
  output logic              frame_end_o,
  output logic              done_o
);
  logic [LINE_W-1:0] line_q, line_d;
  logic              line_en, at_last, done_q;

  always_comb begin
    at_last     = (line_q == last_line_i);
    frame_end_o = step_i & at_last;
    line_en     = arm_i | step_i;
    line_d      = (arm_i | at_last) ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (line_en) line_q <= line_d;
      done_q <= frame_end_o;
    end
  end

  assign done_o = done_q;

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/crc_trig.sv
// Threshold comparison, in-flight tracking, flush queueing, error event.
module crc_trig
  import crc_pkg::*;
#(
  parameter int LVL_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_mode_e       mode_i,
  input  logic [LVL_W-1:0] trigger_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             en_i,
  input  logic             arm_i,
  input  logic             hold_i,
  input  logic             flush_i,
  input  logic             req_done_i,
  input  logic             rd_access_i,
  output logic             wr_req_o,
  output logic             rd_req_o,
  output logic             inflight_o,
  output logic             err_o
);
  logic inflight_q, inflight_d;
  logic flush_q, flush_d;
  logic wr_q, rd_q, err_q, err_d;
  logic is_wr, is_rd, lvl_nz, wr_want, rd_want, can_issue, wr_go, rd_go;

  always_comb begin
    is_wr     = (mode_i == XM_WRITE);
    is_rd     = (mode_i == XM_READ);
    lvl_nz    = |level_i;
    wr_want   = is_wr & ((level_i >= trigger_i) | (flush_q & lvl_nz));
    rd_want   = is_rd & (level_i < trigger_i);
    can_issue = en_i & ~inflight_q & ~hold_i;
    wr_go     = can_issue & wr_want;
    rd_go     = can_issue & rd_want;

    inflight_d = inflight_q;
    if (wr_go | rd_go)   inflight_d = 1'b1;
    else if (req_done_i) inflight_d = 1'b0;

    flush_d = flush_q;
    if (arm_i | ~en_i)                flush_d = 1'b0;
    else if (flush_i & is_wr)         flush_d = 1'b1;
    else if (wr_go)                   flush_d = 1'b0;
    else if (~inflight_q & ~lvl_nz)   flush_d = 1'b0;

    err_d = rd_access_i & en_i & is_rd & ~lvl_nz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= 1'b0;
      flush_q    <= 1'b0;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      inflight_q <= inflight_d;
      flush_q    <= flush_d;
      wr_q       <= wr_go;
      rd_q       <= rd_go;
      err_q      <= err_d;
    end
  end

  assign wr_req_o   = wr_q;
  assign rd_req_o   = rd_q;
  assign inflight_o = inflight_q;
  assign err_o      = err_q;

  a_r3_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q && !req_done_i |=> !wr_q && !rd_q);

  a_r3_direct_silent: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |=> !wr_q && !rd_q);

  a_r1_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);

  a_r9_err_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(mode_i) == XM_READ);
endmodule

// File: rtl/ctx_req_ctrl.sv
module ctx_req_ctrl
  import crc_pkg::*;
#(
  parameter int LVL_W     = 14,
  parameter int LINE_W    = 13,
  parameter int CONT_LAST = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              oneshot_i,
  input  logic [LVL_W-1:0]  trigger_i,
  input  logic [LINE_W-1:0] last_line_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              flush_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              boundary_i,
  input  logic              req_done_i,
  input  logic              rd_access_i,
  output logic              wr_req_o,
  output logic              rd_req_o,
  output logic              enabled_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [LINE_W-1:0] CONT_LINE = LINE_W'(CONT_LAST);

  xfer_mode_e mode;
  logic en, arm, hold, inflight, step, frame_end;

  assign mode = xfer_mode_e'(mode_i);
  assign step = req_done_i & inflight;

  crc_cmd_seq u_cmd (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .boundary_i(boundary_i), .idle_i(~inflight), .frame_end_i(frame_end),
    .oneshot_i(oneshot_i), .en_o(en), .arm_o(arm), .hold_o(hold)
  );

  crc_line_trk #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .step_i(step),
    .last_line_i(last_line_i), .frame_end_o(frame_end), .done_o(done_o)
  );

  crc_trig #(.LVL_W(LVL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .trigger_i(trigger_i),
    .level_i(level_i), .en_i(en), .arm_i(arm), .hold_i(hold),
    .flush_i(flush_i), .req_done_i(req_done_i), .rd_access_i(rd_access_i),
    .wr_req_o(wr_req_o), .rd_req_o(rd_req_o), .inflight_o(inflight),
    .err_o(err_o)
  );

  assign enabled_o = en;

  a_r8_cont_last_line: assert property (@(posedge clk) disable iff (!rst_n)
    en && !oneshot_i |-> last_line_i == CONT_LINE);

  a_r5_no_req_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wr_req_o && !rd_req_o);
endmodule

// File: tb/tb_ctx_req_ctrl.sv
module tb_ctx_req_ctrl;
  logic        clk, rst_n;
  logic [1:0]  mode_i;
  logic        oneshot_i;
  logic [13:0] trigger_i, level_i;
  logic [12:0] last_line_i;
  logic        start_i, stop_i, flush_i, boundary_i, req_done_i, rd_access_i;
  logic        wr_req_o, rd_req_o, enabled_o, done_o, err_o;
  int          n_chk = 0, n_bad = 0;

  ctx_req_ctrl dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic cfg(input int m, input int trig, input int last, input bit os);
    mode_i = m[1:0]; trigger_i = trig[13:0]; last_line_i = last[12:0]; oneshot_i = os;
  endtask

  task automatic do_start();
    boundary_i = 1; start_i = 1; tick(); start_i = 0;
  endtask

  task automatic do_stop();
    boundary_i = 1; stop_i = 1; tick(); stop_i = 0;
  endtask

  task automatic t_reset();
    chk(enabled_o, 0, "R10 enabled after reset");
    chk(wr_req_o | rd_req_o, 0, "R10 requests after reset");
    chk(done_o | err_o, 0, "R10 events after reset");
  endtask

  task automatic t_write();
    level_i = 0; cfg(0, 8, 1, 1);
    do_start();
    chk(enabled_o, 1, "R4 start at boundary enables");
    level_i = 7; tick(); chk(wr_req_o, 0, "R1 level below trigger");
    level_i = 8; tick(); chk(wr_req_o, 1, "R1 level at trigger");
    level_i = 0; tick(); chk(wr_req_o, 0, "R1 single pulse");
    req_done_i = 1; tick(); chk(done_o, 0, "R7 no done mid frame");
    req_done_i = 0; level_i = 9; tick(); chk(wr_req_o, 1, "R1 second line");
    level_i = 0; req_done_i = 1; tick();
    chk(done_o, 1, "R7 done after last line");
    chk(enabled_o, 0, "R8 oneshot disables");
    req_done_i = 0; tick(); chk(done_o, 0, "R7 done is a pulse");
  endtask

  task automatic t_one_line();
    level_i = 0; cfg(0, 8, 0, 1);
    do_start();
    level_i = 8; tick(); chk(wr_req_o, 1, "R7 one-line request");
    level_i = 0; req_done_i = 1; tick();
    chk(done_o, 1, "R7 last line 0 is one line");
    req_done_i = 0; tick();
  endtask

  task automatic t_read_cont();
    level_i = 4; cfg(1, 4, 7, 0);
    do_start();
    chk(rd_req_o, 0, "R2 no read at trigger");
    for (int i = 0; i < 8; i++) begin
      level_i = 3; tick(); chk(rd_req_o, 1, "R2 read below trigger");
      level_i = 4; req_done_i = 1; tick();
      chk(done_o, (i == 7) ? 1 : 0, "R7 read frame done");
      req_done_i = 0;
    end
    chk(enabled_o, 1, "R8 continuous stays enabled");
    tick(); chk(rd_req_o, 0, "R2 no read at trigger after frame");
    boundary_i = 0; stop_i = 1; tick(); stop_i = 0;
    chk(enabled_o, 1, "R5 stop waits for boundary");
    boundary_i = 1; tick(); chk(enabled_o, 0, "R5 stop at boundary");
    oneshot_i = 1;
    level_i = 3; tick(); chk(rd_req_o, 0, "R5 no read while disabled");
  endtask

  task automatic t_stop_prio();
    level_i = 0; cfg(0, 8, 3, 1);
    do_start();
    level_i = 8; tick(); chk(wr_req_o, 1, "R3 request issued");
    level_i = 0; stop_i = 1; tick(); stop_i = 0;
    chk(enabled_o, 1, "R5 stop waits for in-flight request");
    req_done_i = 1; tick(); chk(enabled_o, 1, "R4 boundary gated by in-flight");
    req_done_i = 0; tick(); chk(enabled_o, 0, "R5 stop after completion");
    boundary_i = 0; start_i = 1; tick(); start_i = 0; stop_i = 1; tick(); stop_i = 0;
    chk(enabled_o, 0, "R4 start waits for boundary");
    boundary_i = 1; tick(); chk(enabled_o, 1, "R5 start wins over stop");
    do_stop(); chk(enabled_o, 0, "R5 cleanup stop");
  endtask

  task automatic t_flush();
    level_i = 0; cfg(0, 8, 3, 1);
    do_start();
    level_i = 2; flush_i = 1; tick(); flush_i = 0;
    chk(wr_req_o, 0, "R6 flush takes one cycle to register");
    tick(); chk(wr_req_o, 1, "R6 flush forces write below trigger");
    flush_i = 1; tick(); flush_i = 0; chk(wr_req_o, 0, "R3 no request while in flight");
    tick(); chk(wr_req_o, 0, "R6 flush queued behind in-flight");
    req_done_i = 1; tick(); chk(wr_req_o, 0, "R6 not raised on completion edge");
    req_done_i = 0; tick(); chk(wr_req_o, 1, "R6 queued flush raised");
    req_done_i = 1; tick(); req_done_i = 0;
    cfg(1, 2, 3, 1); level_i = 5; flush_i = 1; tick(); flush_i = 0;
    chk(rd_req_o, 0, "R2 no read above trigger");
    mode_i = 0; trigger_i = 8; tick(); chk(wr_req_o, 0, "R6 flush dropped outside write mode");
    tick(); chk(wr_req_o, 0, "R6 flush dropped outside write mode (later)");
    level_i = 0; do_stop();
  endtask

  task automatic t_direct();
    level_i = 0; cfg(2, 8, 0, 1);
    do_start();
    chk(enabled_o, 1, "R3 direct mode enabled");
    for (int i = 0; i < 4; i++) begin
      level_i = (i[0]) ? 14'd0 : 14'd100; tick();
      chk(wr_req_o | rd_req_o, 0, "R3 direct mode silent");
    end
    mode_i = 3;
    for (int i = 0; i < 4; i++) begin
      level_i = (i[0]) ? 14'd0 : 14'd100; tick();
      chk(wr_req_o | rd_req_o, 0, "R3 reserved mode silent");
    end
    level_i = 0; do_stop();
  endtask

  task automatic t_err();
    level_i = 0; cfg(1, 4, 3, 1);
    do_start();
    rd_access_i = 1; tick(); chk(err_o, 1, "R9 read on empty buffer");
    level_i = 2; tick(); chk(err_o, 0, "R9 no error with data");
    rd_access_i = 0; level_i = 4; req_done_i = 1; tick(); req_done_i = 0;
    do_stop(); chk(enabled_o, 0, "R9 context stopped");
    level_i = 0; rd_access_i = 1; tick(); chk(err_o, 0, "R9 no error while disabled");
    rd_access_i = 0;
  endtask

  initial begin
    rst_n = 0; mode_i = 0; oneshot_i = 1; trigger_i = 8; last_line_i = 0;
    start_i = 0; stop_i = 0; flush_i = 0; level_i = 0; boundary_i = 0;
    req_done_i = 0; rd_access_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_write();
    t_one_line();
    t_read_cont();
    t_stop_prio();
    t_flush();
    t_direct();
    t_err();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule